// File: doc/BRIEF.md
# Serial-Loaded Bank Control Register File

This block holds the bank and mirroring controls of a cartridge-style memory mapper. The CPU does not write a control register in one access. It feeds in one bit per write, and each write lands anywhere in the upper half of the address space. Only data bit 0 of each write is used. The first bit received becomes the least significant bit. When the fifth accepted bit arrives, the assembled 5-bit value is stored. The address of that fifth write alone decides which of four registers receives it.

Two guards sit on the serial path. First, a write on the clock cycle right after another upper-window write is dropped, so accepted bits are always at least two cycles apart. Second, a write with data bit 7 set empties the partial value at once. The stored registers drive the mirroring-mode output, the remaining control bits, two pattern-bank selections and one program-bank selection. Each commit also raises a one-cycle strobe carrying the register index and the value, so that neighbouring logic such as a timer can react to any register being rewritten.

Top module: `bank_serial_loader`

## Requirements
- R1: After reset the control register holds 5'h0C, so mirroring is 0 and the extra control bits read 3. Both pattern banks and the program bank read 0, and the commit strobe is low.
- R2: A register value is built from data bit 0 of five accepted writes, with the first write giving bit 0. Data bits 6:1 have no effect.
- R3: The fifth accepted bit commits the value to the register chosen by address bits 14:13 of that same write: 00 control (0x8000), 01 pattern bank 0 (0xA000), 10 pattern bank 1 (0xC000), 11 program bank (0xE000). The new value shows on the outputs in the cycle after that write. No other register changes.
- R4: `mirror_mode` equals control bits 1:0, coded as 0 single-screen lower, 1 single-screen upper, 2 vertical, 3 horizontal. `ctrl_extra` equals control bits 4:2.
- R5: An upper-window write is ignored if the previous cycle also carried an upper-window write, whether or not that earlier write was accepted.
- R6: An upper-window write with data bit 7 set clears the partial value and the bit count. It is never dropped by the spacing rule, and it changes no register.
- R7: A write with address bit 15 clear is ignored entirely. It is not counted and does not trigger the spacing rule.
- R8: `commit_valid` is high for exactly one cycle after each commit. During that cycle `commit_index` and `commit_value` give the register index (coded as in R3) and the stored value.
- R9: `prg_bank`, `chr_bank0` and `chr_bank1` always equal the stored program and pattern bank registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for this cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| mirror_mode | output | 2 | Nametable mirroring selection |
| ctrl_extra | output | 3 | Control register bits 4:2 |
| chr_bank0 | output | 5 | Pattern bank 0 selection |
| chr_bank1 | output | 5 | Pattern bank 1 selection |
| prg_bank | output | 5 | Program bank selection |
| commit_valid | output | 1 | One-cycle pulse after a register commit |
| commit_index | output | 2 | Register written by the commit |
| commit_value | output | 5 | Value written by the commit |

## Verification
Some rules are checked by assertions on every cycle. The bit count stays in range. A second window write in consecutive cycles leaves the count unchanged. A clear write zeroes the count. The commit pulse never lasts two cycles. Registers move only when a commit is reported, and the register named by the commit then holds the reported value. Other properties can only be shown by the bench's scenarios against its behavioural model. These are the least-significant-first bit order, that only the final write's address picks the target, that the low address half is ignored, and the values mapped to the mirroring code.

// File: rtl/bank_serial_pkg.sv
package bank_serial_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHR0 = 2'd1,
    SEL_CHR1 = 2'd2,
    SEL_PRG  = 2'd3
  } bank_sel_e;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;
endpackage

// File: rtl/serial_shift.sv
module serial_shift #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int VAL_W  = 5,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              load_pulse,
  output logic [IDX_W-1:0]  load_idx,
  output logic [VAL_W-1:0]  load_val
);
  localparam int CNT_W = $clog2(VAL_W);
  localparam int SH_W  = VAL_W - 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VAL_W - 1);

  logic [SH_W-1:0]  shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prev_q, prev_d;
  logic             win_wr, clr_wr, bit_wr, last_bit, shift_en;
  logic             unused_bits;

  assign unused_bits = ^{wr_data[DATA_W-2:1], wr_addr[ADDR_W-IDX_W-2:0]};

  // Decode of the current write
  always_comb begin
    win_wr     = wr_en & wr_addr[ADDR_W-1];
    clr_wr     = win_wr & wr_data[DATA_W-1];
    bit_wr     = win_wr & ~wr_data[DATA_W-1] & ~prev_q;
    last_bit   = (cnt_q == CNT_LAST);
    load_pulse = bit_wr & last_bit;
    load_val   = {wr_data[0], shift_q};
    load_idx   = wr_addr[ADDR_W-2 -: IDX_W];
    shift_en   = clr_wr | bit_wr;
  end

  // Next state of the assembly register
  always_comb begin
    prev_d  = win_wr;
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (clr_wr || (bit_wr && last_bit)) begin
      shift_d = '0;
      cnt_d   = '0;
    end else if (bit_wr) begin
      shift_d = {wr_data[0], shift_q[SH_W-1:1]};
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en) begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R2

  AST_BACK_TO_BACK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && wr_en && wr_addr[ADDR_W-1] && !wr_data[DATA_W-1]) |=> (cnt_q == $past(cnt_q))); // R5

  AST_CLEAR_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[ADDR_W-1] && wr_data[DATA_W-1]) |=> (cnt_q == '0)); // R6

  AST_LOW_HALF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr[ADDR_W-1])) |=> (cnt_q == $past(cnt_q))); // R7
endmodule

// File: rtl/bank_regs.sv
module bank_regs #(
  parameter int VAL_W    = 5,
  parameter int IDX_W    = 2,
  parameter int NUM_REGS = 1 << IDX_W,
  parameter logic [NUM_REGS*VAL_W-1:0] INIT_VALS = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_pulse,
  input  logic [IDX_W-1:0]          load_idx,
  input  logic [VAL_W-1:0]          load_val,
  output logic [NUM_REGS*VAL_W-1:0] regs_flat,
  output logic                      commit_valid,
  output logic [IDX_W-1:0]          commit_index,
  output logic [VAL_W-1:0]          commit_value
);
  logic             cv_q;
  logic [IDX_W-1:0] ci_q;
  logic [VAL_W-1:0] cval_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [VAL_W-1:0] q;
    logic             en;
    assign en = load_pulse && (load_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= INIT_VALS[g*VAL_W +: VAL_W];
      end else if (en) begin
        q <= load_val;
      end
    end
    assign regs_flat[g*VAL_W +: VAL_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b0;
    end else begin
      cv_q <= load_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci_q   <= '0;
      cval_q <= '0;
    end else if (load_pulse) begin
      ci_q   <= load_idx;
      cval_q <= load_val;
    end
  end

  assign commit_valid = cv_q;
  assign commit_index = ci_q;
  assign commit_value = cval_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q |=> !cv_q); // R8

  AST_COMMIT_MATCHES_REG: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q |-> (regs_flat[ci_q*VAL_W +: VAL_W] == cval_q)); // R3

  AST_HOLD_UNLESS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cv_q |-> $stable(regs_flat)); // R3
endmodule

// File: rtl/bank_serial_loader.sv
module bank_serial_loader
  import bank_serial_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int VAL_W  = 5,
  parameter int IDX_W  = 2,
  parameter logic [VAL_W-1:0] CTRL_INIT = 5'h0C,
  parameter logic [VAL_W-1:0] BANK_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        mirror_mode,
  output logic [VAL_W-3:0]  ctrl_extra,
  output logic [VAL_W-1:0]  chr_bank0,
  output logic [VAL_W-1:0]  chr_bank1,
  output logic [VAL_W-1:0]  prg_bank,
  output logic              commit_valid,
  output logic [IDX_W-1:0]  commit_index,
  output logic [VAL_W-1:0]  commit_value
);
  localparam int NUM_REGS = 1 << IDX_W;
  localparam logic [NUM_REGS*VAL_W-1:0] INIT_VALS = {BANK_INIT, BANK_INIT, BANK_INIT, CTRL_INIT};

  logic                      load_pulse;
  logic [IDX_W-1:0]          load_idx;
  logic [VAL_W-1:0]          load_val;
  logic [NUM_REGS*VAL_W-1:0] regs_flat;
  logic [VAL_W-1:0]          ctrl_q;
  mirror_e                   mir;

  serial_shift #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .IDX_W(IDX_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_pulse(load_pulse), .load_idx(load_idx), .load_val(load_val)
  );

  bank_regs #(
    .VAL_W(VAL_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .INIT_VALS(INIT_VALS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .load_idx(load_idx),
    .load_val(load_val), .regs_flat(regs_flat), .commit_valid(commit_valid),
    .commit_index(commit_index), .commit_value(commit_value)
  );

  assign ctrl_q      = regs_flat[int'(SEL_CTRL)*VAL_W +: VAL_W];
  assign mir         = mirror_e'(ctrl_q[1:0]);
  assign mirror_mode = mir;
  assign ctrl_extra  = ctrl_q[VAL_W-1:2];
  assign chr_bank0   = regs_flat[int'(SEL_CHR0)*VAL_W +: VAL_W];
  assign chr_bank1   = regs_flat[int'(SEL_CHR1)*VAL_W +: VAL_W];
  assign prg_bank    = regs_flat[int'(SEL_PRG)*VAL_W +: VAL_W];

  AST_COMMIT_ONLY_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> (wr_en && wr_addr[ADDR_W-1])); // R7
endmodule

// File: tb/bank_serial_loader_test.sv
`timescale 1ns/1ps
module bank_serial_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  mirror_mode;
  logic [2:0]  ctrl_extra;
  logic [4:0]  chr_bank0, chr_bank1, prg_bank, commit_value;
  logic        commit_valid;
  logic [1:0]  commit_index;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_cnt, m_val, m_prev, m_cv, m_ci, m_cval;
  int m_reg [4];

  bank_serial_loader uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mirror_mode(mirror_mode), .ctrl_extra(ctrl_extra), .chr_bank0(chr_bank0),
    .chr_bank1(chr_bank1), .prg_bank(prg_bank), .commit_valid(commit_valid),
    .commit_index(commit_index), .commit_value(commit_value)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_val = 0; m_prev = 0; m_cv = 0; m_ci = 0; m_cval = 0;
      m_reg[0] = 12; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
    end else begin
      m_cv = 0;
      if (wr_en && wr_addr[15]) begin
        if (wr_data[7]) begin
          m_cnt = 0; m_val = 0;
        end else if (!m_prev) begin
          m_val = m_val | (int'(wr_data[0]) << m_cnt);
          m_cnt++;
          if (m_cnt == 5) begin
            m_ci = int'(wr_addr[14:13]);
            m_reg[m_ci] = m_val;
            m_cval = m_val; m_cv = 1;
            m_cnt = 0; m_val = 0;
          end
        end
      end
      m_prev = (wr_en && wr_addr[15]) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 mirror", mirror_mode, m_reg[0] & 3);
      check("R4 ctrl_extra", ctrl_extra, m_reg[0] >> 2);
      check("R9 chr_bank0", chr_bank0, m_reg[1]);
      check("R9 chr_bank1", chr_bank1, m_reg[2]);
      check("R9 prg_bank", prg_bank, m_reg[3]);
      check("R8 commit_valid", commit_valid, m_cv);
      if (m_cv != 0) begin
        check("R8 commit_index", commit_index, m_ci);
        check("R8 commit_value", commit_value, m_cval);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr2(input logic [15:0] a, input logic [7:0] d1, input logic [7:0] d2);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d1;
    @(negedge clk);
    wr_data = d2;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sw(input logic [15:0] a, input logic [4:0] v);
    for (int b = 0; b < 5; b++) wr(a, {7'b0, v[b]});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mirror", mirror_mode, 0);
    check("R1 ctrl_extra", ctrl_extra, 3);
    check("R1 prg", prg_bank, 0);
    check("R1 commit", commit_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 chr0 after release", chr_bank0, 0);

    // R3 R8 R9: program bank 5, strobe one cycle after last write
    sw(16'hE000, 5'd5);
    check("R8 strobe", commit_valid, 1);
    check("R8 index", commit_index, 3);
    check("R8 value", commit_value, 5);
    check("R9 prg", prg_bank, 5);
    @(negedge clk);
    check("R8 strobe drops", commit_valid, 0);

    // R4 every mirroring code
    for (int m = 0; m < 4; m++) begin
      sw(16'h8000, 5'(m | 8));
      check("R4 mirror code", mirror_mode, m);
      check("R4 extra bits", ctrl_extra, 2);
    end

    // R3 only the last address matters
    for (int b = 0; b < 4; b++) wr(16'h8000, {7'b0, 1'(5'h13 >> b)});
    wr(16'hA000, 8'h01);
    check("R3 last addr chr0", chr_bank0, 5'h13);
    check("R3 control untouched", mirror_mode, 3);

    // R2 upper data bits ignored, LSB first (0x0A)
    for (int b = 0; b < 5; b++) wr(16'hF123, 8'h7E | 8'(1'(5'h0A >> b)));
    check("R2 lsb first", prg_bank, 5'h0A);

    // R5 back-to-back: second write dropped; 0x15 expected
    wr2(16'hC000, 8'h01, 8'h00);
    wr(16'hC000, 8'h00); wr(16'hC000, 8'h01); wr(16'hC000, 8'h00); wr(16'hC000, 8'h01);
    check("R5 filtered chr1", chr_bank1, 5'h15);

    // R6 clear mid-sequence, clear right after a write is not filtered
    wr(16'hE000, 8'h01); wr(16'hE000, 8'h01);
    wr(16'hE000, 8'h80);
    check("R6 no reg change", prg_bank, 5'h0A);
    wr2(16'hE000, 8'h01, 8'hFF);
    sw(16'hE000, 5'h0C);
    check("R6 clean restart", prg_bank, 5'h0C);

    // R7 low-half writes neither count nor space
    wr(16'h6000, 8'h01); wr(16'h0000, 8'h01); wr(16'h7FFF, 8'h81);
    check("R7 no effect", prg_bank, 5'h0C);
    for (int b = 0; b < 5; b++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h6000; wr_data = 8'h01;
      @(negedge clk);
      wr_addr = 16'hE000; wr_data = {7'b0, 1'(5'h11 >> b)};
      @(negedge clk);
      wr_en = 1'b0;
    end
    check("R7 interleaved", prg_bank, 5'h11);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule